// File: doc/BRIEF.md
# Serial ROM Command Engine

This block lets a host drive a word-addressed serial ROM through a small set of byte-wide registers. The host loads an address and, for writes, a data word into two byte pairs. It then writes a command code into the command/status register and polls that register until the done bit appears. The engine supports four commands: read a word, write a word, enable writes and disable writes. It performs one word transfer on a request/acknowledge memory port. After an enable, a disable or a word write, it waits out a settle time counted in clock cycles before it reports done. Read data is placed in the data registers before done rises.

Writes are guarded. The write-enable command has to run first; a write issued without it finishes at once with an error and leaves the ROM untouched. Reads need no guard. The settle times are given in milliseconds and are converted to cycles with a clock-rate parameter. The ROM modelled here holds 256 words (8 address bits by default), and its final byte carries a checksum over the whole array. That checksum is content which the host writes like any other data.

Top module: `srom_cmd_engine`

## Requirements
- R1: Registers are selected by `reg_sel` as follows: 0 command/status, 1 address low, 2 address high, 3 data low, 4 data high. `reg_rdata` returns the selected register in the same cycle. The address and data registers read back the last value written to them.
- R2: The status byte contains bit 6 busy, bit 5 write-enabled, bit 4 error, bit 3 done and bits 2:0 the low bits of the last command code. After reset the status byte is 0x00.
- R3: The accepted command bytes are 0 idle, 1 write, 2 read, 4 enable-write and 7 disable-write. Idle starts no operation. Any other byte completes at once, with done and error set in the status read right after the command write.
- R4: A read makes one ROM request with `rom_we` low. The address is the low ADDR_W bits of {address high, address low}. The returned word is latched into data high/low before done is set. Done appears 2 cycles after the command write when the ROM acknowledges one cycle after its request.
- R5: With writes enabled, a write makes one ROM request with `rom_we` high and data {data high, data low}. The engine then settles for WR_SETTLE_MS·CLK_HZ/1000 cycles after the acknowledge. Done appears settle+3 cycles after the command write when the ROM acknowledges one cycle after its request.
- R6: A write issued while writes are disabled makes no ROM request and leaves the ROM unchanged. It sets done and error in the status read right after the command write.
- R7: Enable-write sets write-enabled and settles for EN_SETTLE_MS·CLK_HZ/1000 cycles. Done appears settle+1 cycles after the command write.
- R8: Disable-write clears write-enabled and settles for the same enable settle time, with the same done latency.
- R9: Writing a command byte clears done and error. While busy, every host register write is ignored.
- R10: `rom_req` is low while idle. Once raised, it stays high until `rom_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Selected register contents |
| rom_req | output | 1 | ROM word transfer request |
| rom_we | output | 1 | Transfer is a write |
| rom_addr | output | ADDR_W | ROM word address |
| rom_wdata | output | 16 | Word to write |
| rom_rdata | input | 16 | Word read from ROM |
| rom_ack | input | 1 | ROM transfer acknowledge |

## Verification
Several rules are checked by assertions on every cycle. A ROM request holds until its acknowledge. No ROM write request appears without the write-enabled flag. Done and busy are never set together. Command writes during busy leave the stored code alone. An acknowledged read lands in the data registers. A freshly started settle timer is never already expired. Only the bench scenarios can show the exact done latencies for each command. They also show that the ROM contents change or stay put as the guard demands, that unknown codes raise the error, and that address and data writes are ignored while busy.

// File: rtl/srom_pkg.sv
package srom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACCESS,
      ST_SETTLE
   } srom_state_e;

   localparam logic [7:0] CODE_IDLE  = 8'd0;
   localparam logic [7:0] CODE_WRITE = 8'd1;
   localparam logic [7:0] CODE_READ  = 8'd2;
   localparam logic [7:0] CODE_WREN  = 8'd4;
   localparam logic [7:0] CODE_WRDIS = 8'd7;

   localparam logic [2:0] SEL_CMD = 3'd0;
   localparam logic [2:0] SEL_ALO = 3'd1;
   localparam logic [2:0] SEL_AHI = 3'd2;
   localparam logic [2:0] SEL_DLO = 3'd3;
   localparam logic [2:0] SEL_DHI = 3'd4;

   localparam int STAT_DONE = 3;
   localparam int STAT_ERR  = 4;
   localparam int STAT_WEN  = 5;
   localparam int STAT_BUSY = 6;

endpackage

// File: rtl/srom_settle_timer.sv
module srom_settle_timer #(
   parameter int unsigned LONG_CYC  = 500,
   parameter int unsigned SHORT_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic use_long,
   output logic expired
);
   localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int CNT_W = $clog2(MAX_CYC + 1);

   generate
      if (LONG_CYC < 1 || SHORT_CYC < 1) begin : g_bad_len
         $error("settle lengths must be at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= use_long ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R7
   start_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !expired);

endmodule

// File: rtl/srom_host_regs.sv
module srom_host_regs
   import srom_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  sel,
   input  logic [7:0]  wdata,
   input  logic        load_rd,
   input  logic [15:0] rd_word,
   output logic [15:0] addr_word,
   output logic [15:0] data_word
);
   logic [7:0] alo_q, ahi_q, dlo_q, dhi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alo_q <= '0;
         ahi_q <= '0;
         dlo_q <= '0;
         dhi_q <= '0;
      end else begin
         if (wr_en && sel == SEL_ALO) alo_q <= wdata;
         if (wr_en && sel == SEL_AHI) ahi_q <= wdata;
         if (load_rd) begin
            dlo_q <= rd_word[7:0];
            dhi_q <= rd_word[15:8];
         end else begin
            if (wr_en && sel == SEL_DLO) dlo_q <= wdata;
            if (wr_en && sel == SEL_DHI) dhi_q <= wdata;
         end
      end
   end

   assign addr_word = {ahi_q, alo_q};
   assign data_word = {dhi_q, dlo_q};

   // R4
   rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_rd |=> data_word == $past(rd_word));

endmodule

// File: rtl/srom_cmd_engine.sv
module srom_cmd_engine
   import srom_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned CLK_HZ       = 125_000_000,
   parameter int unsigned EN_SETTLE_MS = 500,
   parameter int unsigned WR_SETTLE_MS = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              rom_req,
   output logic              rom_we,
   output logic [ADDR_W-1:0] rom_addr,
   output logic [15:0]       rom_wdata,
   input  logic [15:0]       rom_rdata,
   input  logic              rom_ack
);
   localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
   localparam int unsigned EN_CYC     = EN_SETTLE_MS * CYC_PER_MS;
   localparam int unsigned WR_CYC     = WR_SETTLE_MS * CYC_PER_MS;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 1..16");
      end
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("CLK_HZ must be at least 1000");
      end
   endgenerate

   srom_state_e state_q;
   logic [2:0]  code_q;
   logic        done_q, err_q, wen_q, is_wr_q;
   logic        busy, host_wr, cmd_wr, tmr_start, tmr_long, tmr_expired, load_rd;
   logic [15:0] addr_word, data_word;

   assign busy    = (state_q != ST_IDLE);
   assign host_wr = reg_we && !busy;
   assign cmd_wr  = host_wr && (reg_sel == SEL_CMD);
   assign load_rd = (state_q == ST_ACCESS) && rom_ack && !is_wr_q;

   assign tmr_long  = (state_q == ST_IDLE);
   assign tmr_start = (cmd_wr && (reg_wdata == CODE_WREN || reg_wdata == CODE_WRDIS))
                    || ((state_q == ST_ACCESS) && rom_ack && is_wr_q);

   srom_settle_timer #(
      .LONG_CYC  (EN_CYC),
      .SHORT_CYC (WR_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tmr_start),
      .use_long (tmr_long),
      .expired  (tmr_expired)
   );

   srom_host_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (host_wr),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .load_rd   (load_rd),
      .rd_word   (rom_rdata),
      .addr_word (addr_word),
      .data_word (data_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         wen_q   <= 1'b0;
         is_wr_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_wr) begin
                  code_q <= reg_wdata[2:0];
                  done_q <= 1'b0;
                  err_q  <= 1'b0;
                  case (reg_wdata)
                     CODE_IDLE: ;
                     CODE_WRITE: begin
                        if (wen_q) begin
                           is_wr_q <= 1'b1;
                           state_q <= ST_ACCESS;
                        end else begin
                           done_q <= 1'b1;
                           err_q  <= 1'b1;
                        end
                     end
                     CODE_READ: begin
                        is_wr_q <= 1'b0;
                        state_q <= ST_ACCESS;
                     end
                     CODE_WREN: begin
                        wen_q   <= 1'b1;
                        state_q <= ST_SETTLE;
                     end
                     CODE_WRDIS: begin
                        wen_q   <= 1'b0;
                        state_q <= ST_SETTLE;
                     end
                     default: begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                     end
                  endcase
               end
            end
            ST_ACCESS: begin
               if (rom_ack) begin
                  if (is_wr_q) begin
                     state_q <= ST_SETTLE;
                  end else begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_SETTLE: begin
               if (tmr_expired) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rom_req   = (state_q == ST_ACCESS);
   assign rom_we    = is_wr_q;
   assign rom_wdata = data_word;

   generate
      if (ADDR_W <= 8) begin : g_addr_narrow
         assign rom_addr = addr_word[ADDR_W-1:0];
      end else begin : g_addr_wide
         assign rom_addr = {addr_word[ADDR_W-1:8], addr_word[7:0]};
      end
   endgenerate

   always_comb begin
      case (reg_sel)
         SEL_CMD: begin
            reg_rdata            = {5'b0, code_q};
            reg_rdata[STAT_DONE] = done_q;
            reg_rdata[STAT_ERR]  = err_q;
            reg_rdata[STAT_WEN]  = wen_q;
            reg_rdata[STAT_BUSY] = busy;
         end
         SEL_ALO: reg_rdata = addr_word[7:0];
         SEL_AHI: reg_rdata = addr_word[15:8];
         SEL_DLO: reg_rdata = data_word[7:0];
         SEL_DHI: reg_rdata = data_word[15:8];
         default: reg_rdata = 8'h00;
      endcase
   end

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req && !rom_ack |=> rom_req);

   // R6
   wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req && rom_we |-> wen_q);

   // R2
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && busy));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && reg_we && reg_sel == SEL_CMD |=> code_q == $past(code_q));

endmodule

// File: tb/test_srom_cmd_engine.sv
module test_srom_cmd_engine;
   localparam int unsigned TB_HZ = 1000;
   localparam int unsigned EN_N  = 500;
   localparam int unsigned WR_N  = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        rom_req, rom_we;
   logic [7:0]  rom_addr;
   logic [15:0] rom_wdata;
   logic [15:0] rom_rdata = 16'd0;
   logic        rom_ack = 1'b0;

   logic [15:0] mem [256];
   int          req_cnt = 0;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   srom_cmd_engine #(.ADDR_W(8), .CLK_HZ(TB_HZ), .EN_SETTLE_MS(500), .WR_SETTLE_MS(20))
   i_srom_cmd_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rom_req(rom_req),
      .rom_we(rom_we), .rom_addr(rom_addr), .rom_wdata(rom_wdata),
      .rom_rdata(rom_rdata), .rom_ack(rom_ack));

   always @(posedge clk) begin
      if (rom_req && !rom_ack) begin
         rom_ack <= 1'b1;
         req_cnt <= req_cnt + 1;
         if (rom_we) mem[rom_addr] <= rom_wdata;
         else        rom_rdata <= mem[rom_addr];
      end else begin
         rom_ack <= 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
      reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] sel, output logic [7:0] val);
      reg_sel = sel; #1;
      val = reg_rdata;
   endtask

   task automatic wait_done(output int n);
      logic [7:0] s;
      n = 0;
      rd_reg(3'd0, s);
      while (!s[3] && n < 5000) begin
         @(posedge clk); #1;
         n++;
         rd_reg(3'd0, s);
      end
   endtask

   task automatic t_reset;
      logic [7:0] s;
      rd_reg(3'd0, s);
      check("R2 reset status", s, 8'h00);
      check("R10 idle req", rom_req, 0);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      wr_reg(3'd1, 8'h12); wr_reg(3'd2, 8'h00);
      wr_reg(3'd3, 8'hEF); wr_reg(3'd4, 8'hBE);
      rd_reg(3'd1, v); check("R1 addr low", v, 8'h12);
      rd_reg(3'd3, v); check("R1 data low", v, 8'hEF);
      rd_reg(3'd4, v); check("R1 data high", v, 8'hBE);
   endtask

   task automatic t_guarded_write;
      logic [7:0] s; int n; int rc;
      rc = req_cnt;
      wr_reg(3'd0, 8'd1);
      wait_done(n);
      check("R6 latency", n, 0);
      rd_reg(3'd0, s); check("R6 status", s, 8'h19);
      repeat (3) @(posedge clk); #1;
      check("R6 no request", req_cnt, rc);
      check("R6 rom unchanged", mem[8'h12], 16'hA000 ^ (16'h12 * 16'd257));
   endtask

   task automatic t_enable;
      logic [7:0] s; int n;
      wr_reg(3'd0, 8'd4);
      rd_reg(3'd0, s); check("R7 busy status", s, 8'h64);
      wr_reg(3'd1, 8'h55);
      wr_reg(3'd0, 8'd2);
      wait_done(n);
      check("R7 latency", n + 2, EN_N + 1);
      rd_reg(3'd0, s); check("R9 code kept while busy", s, 8'h2C);
      rd_reg(3'd1, s); check("R9 addr kept while busy", s, 8'h12);
   endtask

   task automatic t_write;
      logic [7:0] s; int n; int rc;
      rc = req_cnt;
      wr_reg(3'd0, 8'd1);
      wait_done(n);
      check("R5 latency", n, WR_N + 3);
      check("R5 rom word", mem[8'h12], 16'hBEEF);
      check("R5 one request", req_cnt, rc + 1);
      rd_reg(3'd0, s); check("R5 status", s, 8'h29);
   endtask

   task automatic t_read;
      logic [7:0] lo, hi, s; int n;
      wr_reg(3'd1, 8'h40); wr_reg(3'd2, 8'h01);
      wr_reg(3'd3, 8'h00); wr_reg(3'd4, 8'h00);
      wr_reg(3'd0, 8'd2);
      wait_done(n);
      check("R4 latency", n, 2);
      rd_reg(3'd3, lo); rd_reg(3'd4, hi);
      check("R4 read word", {hi, lo}, 16'hA000 ^ (16'h40 * 16'd257));
      rd_reg(3'd0, s); check("R4 status", s, 8'h2A);
      wr_reg(3'd1, 8'h12);
      wr_reg(3'd0, 8'd2);
      wait_done(n);
      rd_reg(3'd3, lo); rd_reg(3'd4, hi);
      check("R4 read back written", {hi, lo}, 16'hBEEF);
   endtask

   task automatic t_codes;
      logic [7:0] s; int n;
      wr_reg(3'd0, 8'd5);
      wait_done(n);
      check("R3 unknown latency", n, 0);
      rd_reg(3'd0, s); check("R3 unknown status", s, 8'h3D);
      wr_reg(3'd0, 8'd0);
      rd_reg(3'd0, s); check("R9 idle clears done", s, 8'h20);
   endtask

   task automatic t_disable;
      logic [7:0] s; int n; int rc;
      wr_reg(3'd0, 8'd7);
      wait_done(n);
      check("R8 latency", n, EN_N + 1);
      rd_reg(3'd0, s); check("R8 status", s, 8'h0F);
      rc = req_cnt;
      wr_reg(3'd1, 8'h13);
      wr_reg(3'd0, 8'd1);
      repeat (3) @(posedge clk); #1;
      rd_reg(3'd0, s); check("R8 write refused", s, 8'h19);
      check("R8 no request", req_cnt, rc);
      check("R8 rom unchanged", mem[8'h13], 16'hA000 ^ (16'h13 * 16'd257));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ (16'(i) * 16'd257);
      repeat (3) @(posedge clk); #1;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_regs();
      t_guarded_write();
      t_enable();
      t_write();
      t_read();
      t_codes();
      t_disable();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule